// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire management bus used to configure Ethernet PHYs. Software fills an address register and a write-data register, then writes a command word that selects the frame type, the PHY address and the register or device number, with the start bit set. The block serialises one 64-bit management frame on the MDC/MDIO pins. It clears the start bit when the frame ends. For read frames it also updates a read-data register and a read-failure status bit.

MDC is derived from the system clock by a fixed divider and runs continuously. Each frame carries 32 preamble ones, a two-bit start code taken from the command's frame-type field, two opcode bits, the PHY address, the register or device number, a two-bit turnaround and sixteen data bits. Both the old register-number frames and the extended address/data frames are supported. For extended accesses, software issues the address frame first and the data frame after it.

Top module: `mdio_master`

## Requirements
- R1: The bus word index `bus_addr_i[4:2]` selects the register: 0 command, 1 extended address, 2 write data, 3 read data, 4 status. Address and write-data registers store bits 15:0 and read back with bits 31:16 at zero. The read-data and status registers ignore writes.
- R2: Command bits are devnum 4:0, PHY address 9:5, opcode 11:10, frame type 13:12 and start 14. The stored fields read back unchanged, with bits 31:15 apart from start at zero.
- R3: After reset MDC is low and toggles every `HALF_DIV` system clocks, so one MDC period is `2*HALF_DIV` clocks.
- R4: A frame is 64 bits, MSB first: 32 ones, then the frame-type field's two bits (type 0 sends 00 for extended frames, type 1 sends 01 for register-number frames), opcode, PHY address, devnum, turnaround and 16 data bits. MDIO changes only in the clock where MDC falls.
- R5: Write frames (type 1 op 1, type 0 op 1) send turnaround 10 and the write-data register. An extended address frame (type 0 op 0) sends turnaround 10 and the address register.
- R6: Read frames (type 1 op 2, type 0 op 2 or 3) drive `mdio_oe_o` low from the first turnaround bit to the end of the frame. The 16 bits sampled on MDC rising edges, MSB first, are loaded into the read-data register at completion.
- R7: In a read frame the second turnaround bit is sampled on its MDC rising edge. A high value sets status bit 0 at completion and a low value clears it. Write and address frames leave the bit unchanged.
- R8: A command write with bit 14 set while start reads 0 sets start in the same clock. The frame begins at the next MDC falling edge, and start returns to 0 in the clock of the MDC rising edge that samples the 64th bit.
- R9: A command write while start reads 1 is ignored: the stored fields do not change and no further frame is sent.
- R10: Reset clears start, status, read data and all command fields, and leaves `mdio_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe, one clock per write |
| bus_addr_i | input | 3 | Register word index (byte offset bits 4:2) |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the index |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A frame launched by a command write starts at the first MDC falling edge after that write. It then takes 64 MDC periods, and start, status and read data all change in the clock of the last MDC rising edge. The bench holds a behavioural model that steps an integer MDC counter and a 64-entry queue of expected bit and enable values in the same clock edges. It compares MDC, the enable and the driven data at every falling system-clock edge, so each result is checked in exactly the cycle it is due. Register results are read through the bus only after the polled start bit has gone to zero. Every poll of the start bit is itself compared against the model's busy state.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned TA_IDX     = 46;  // first turnaround bit
  localparam int unsigned DATA_IDX   = 48;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam int unsigned START_BIT  = 14;
  localparam int unsigned FLD_W      = 14;

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] op;
    logic [4:0] prtad;
    logic [4:0] devad;
  } cmd_t;

  typedef enum logic [2:0] {
    REG_CMD   = 3'd0,
    REG_ADDR  = 3'd1,
    REG_WDATA = 3'd2,
    REG_RDATA = 3'd3,
    REG_STAT  = 3'd4
  } reg_idx_e;

  function automatic logic is_read(cmd_t c);
    if (c.st == 2'd1) return c.op == 2'd2;
    return (c.st == 2'd0) && c.op[1];
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap & ~mdc_q;
  assign fall_o = wrap & mdc_q;

  // R3
  mdc_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdc_q) |-> $past(wrap));
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [4:2]        bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic              rd_err_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output cmd_t              cmd_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              launch_o
);
  cmd_t              cmd_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic              err_q;
  logic              cmd_we;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata_i[BUS_W-1:DATA_W];
  assign cmd_we    = bus_we_i && (bus_addr_i == REG_CMD);
  assign launch_o  = cmd_we && !busy_i && bus_wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (cmd_we && !busy_i) cmd_q <= cmd_t'(bus_wdata_i[FLD_W-1:0]);
      if (bus_we_i && bus_addr_i == REG_ADDR)  addr_q  <= bus_wdata_i[DATA_W-1:0];
      if (bus_we_i && bus_addr_i == REG_WDATA) wdata_q <= bus_wdata_i[DATA_W-1:0];
      if (done_i && done_rd_i) begin
        rdata_q <= rd_data_i;
        err_q   <= rd_err_i;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_CMD:   bus_rdata_o = BUS_W'({busy_i, cmd_q});
      REG_ADDR:  bus_rdata_o = BUS_W'(addr_q);
      REG_WDATA: bus_rdata_o = BUS_W'(wdata_q);
      REG_RDATA: bus_rdata_o = BUS_W'(rdata_q);
      REG_STAT:  bus_rdata_o = BUS_W'(err_q);
      default:   bus_rdata_o = '0;
    endcase
  end

  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && busy_i) |=> $stable(cmd_q));
  // R8
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> busy_i);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              launch_i,
  input  cmd_t              cmd_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic              rd_err_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic                  pend_q, run_q, rd_q, oe_q, out_q, ta_bad_q;
  logic [CNT_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q, frame_w;
  logic [DATA_W-1:0]     rx_q, payload;
  logic                  rd_w, last;

  assign rd_w    = is_read(cmd_i);
  assign payload = (cmd_i.st == 2'd0 && cmd_i.op == 2'd0) ? addr_i : wdata_i;
  assign frame_w = {{PRE_BITS{1'b1}}, cmd_i.st, cmd_i.op, cmd_i.prtad, cmd_i.devad,
                    rd_w ? 2'b11 : 2'b10, rd_w ? {DATA_W{1'b1}} : payload};
  assign last    = run_q && rise_i && (idx_q == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      rd_q     <= 1'b0;
      oe_q     <= 1'b0;
      out_q    <= 1'b1;
      ta_bad_q <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      if (launch_i) pend_q <= 1'b1;
      if (fall_i && pend_q) begin
        pend_q   <= 1'b0;
        run_q    <= 1'b1;
        rd_q     <= rd_w;
        sh_q     <= frame_w << 1;
        out_q    <= frame_w[FRAME_BITS-1];
        oe_q     <= 1'b1;
        idx_q    <= '0;
        ta_bad_q <= 1'b0;
      end else if (fall_i && run_q) begin
        out_q <= sh_q[FRAME_BITS-1];
        sh_q  <= sh_q << 1;
        idx_q <= idx_q + 1'b1;
        if (rd_q && idx_q == CNT_W'(TA_IDX - 1)) oe_q <= 1'b0;
      end
      if (rise_i && run_q && rd_q) begin
        if (idx_q == CNT_W'(TA_IDX + 1)) ta_bad_q <= mdio_i;
        if (idx_q >= CNT_W'(DATA_IDX))   rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      end
      if (last) begin
        run_q <= 1'b0;
        oe_q  <= 1'b0;
        out_q <= 1'b1;
      end
    end
  end

  assign busy_o    = pend_q | run_q;
  assign done_o    = last;
  assign done_rd_o = rd_q;
  assign rd_err_o  = ta_bad_q;
  assign rd_data_o = {rx_q[DATA_W-2:0], mdio_i};
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);
  // R6
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && rd_q && idx_q >= CNT_W'(TA_IDX)) |-> !mdio_oe_o);
  // R4
  fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !$stable(out_q)) |-> $past(fall_i));
  // R8
  end_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(run_q && rise_i && idx_q == CNT_W'(FRAME_BITS - 1)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned DATA_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [4:2]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic              rise, fall, busy, done, done_rd, rd_err, launch;
  logic [DATA_W-1:0] rd_data, addr, wdata;
  cmd_t              cmd;

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk_i(clk_i), .rst_ni(rst_ni), .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_csr #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .busy_i(busy),
    .done_i(done), .done_rd_i(done_rd), .rd_err_i(rd_err), .rd_data_i(rd_data),
    .cmd_o(cmd), .addr_o(addr), .wdata_o(wdata), .launch_o(launch)
  );

  mdio_frame_eng #(.DATA_W(DATA_W)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall), .launch_i(launch),
    .cmd_i(cmd), .addr_i(addr), .wdata_i(wdata), .mdio_i(mdio_i), .busy_o(busy),
    .done_o(done), .done_rd_o(done_rd), .rd_err_o(rd_err), .rd_data_o(rd_data),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  int vectors = 0, errors = 0;
  bit finished = 0;

  // behavioural reference
  int        m_cnt, m_idx;
  bit        m_mdc, m_pend, m_run, m_rd, m_out, m_oe, m_rise, m_fall, m_busy_pre;
  bit        m_bits[64];
  bit        m_oes[64];
  bit [13:0] m_cmd;
  bit [15:0] m_addr, m_wdata;
  bit [63:0] m_f;
  bit [15:0] phy_data;
  bit        phy_ta_ok;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mdc = 0; m_pend = 0; m_run = 0; m_rd = 0; m_oe = 0; m_out = 1;
      m_idx = 0; m_cmd = '0; m_addr = '0; m_wdata = '0;
    end else begin
      m_busy_pre = m_pend || m_run;
      m_rise = (m_cnt == HALF - 1) && !m_mdc;
      m_fall = (m_cnt == HALF - 1) && m_mdc;
      if (m_cnt == HALF - 1) begin m_cnt = 0; m_mdc = !m_mdc; end
      else m_cnt++;
      if (m_rise && m_run && m_idx == 63) begin m_run = 0; m_oe = 0; end
      if (m_fall && m_run) begin
        m_idx++; m_out = m_bits[m_idx]; m_oe = m_oes[m_idx];
      end else if (m_fall && m_pend) begin
        m_rd = (m_cmd[13:12] == 2'd1) ? (m_cmd[11:10] == 2'd2)
             : (m_cmd[13:12] == 2'd0 && m_cmd[11]);
        m_f = {32'hFFFF_FFFF, m_cmd, m_rd ? 2'b11 : 2'b10,
               m_rd ? 16'hFFFF : ((m_cmd[13:10] == 4'd0) ? m_addr : m_wdata)};
        for (int i = 0; i < 64; i++) begin
          m_bits[i] = m_f[63-i];
          m_oes[i]  = !(m_rd && i >= 46);
        end
        m_pend = 0; m_run = 1; m_idx = 0; m_out = m_bits[0]; m_oe = 1;
      end
      if (bus_we && bus_addr == 3'd0 && !m_busy_pre) begin
        m_cmd = bus_wdata[13:0];
        if (bus_wdata[14]) m_pend = 1;
      end
      if (bus_we && bus_addr == 3'd1) m_addr = bus_wdata[15:0];
      if (bus_we && bus_addr == 3'd2) m_wdata = bus_wdata[15:0];
    end
  end

  // per-clock comparison and PHY response
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 mdc", 32'(mdc), 32'(m_mdc));
      chk("R6 R10 mdio_oe", 32'(mdio_oe), 32'(m_oe));
      if (m_oe) chk("R4 R5 mdio bit", 32'(mdio_o), 32'(m_out));
    end
    if (m_run && m_rd && m_idx == 47)     mdio_i = !phy_ta_ok;
    else if (m_run && m_rd && m_idx >= 48) mdio_i = phy_data[63-m_idx];
    else                                   mdio_i = 1'b1;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input bit [1:0] st, input bit [1:0] op,
                                           input bit [4:0] prt, input bit [4:0] dev);
    return {17'd0, 1'b1, st, op, prt, dev};
  endfunction

  task automatic wait_done();
    logic [31:0] v;
    for (int n = 0; n < 2000; n++) begin
      rd(3'd0, v);
      chk("R8 start poll", 32'(v[14]), 32'(m_pend || m_run));
      if (!v[14]) return;
    end
    chk("R8 start never cleared", 32'(1), 32'(0));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    rd(3'd0, v); chk("R10 cmd after reset", v, 32'h0);
    rd(3'd4, v); chk("R10 status after reset", v, 32'h0);
    rd(3'd3, v); chk("R10 rdata after reset", v, 32'h0);
    chk("R10 oe in reset", 32'(mdio_oe), 32'h0);
    rst_n = 1'b1;

    // R1 register map
    wr(3'd1, 32'h1234_ABCD); rd(3'd1, v); chk("R1 addr readback", v, 32'h0000_ABCD);
    wr(3'd2, 32'hFFFF_5A5A); rd(3'd2, v); chk("R1 wdata readback", v, 32'h0000_5A5A);
    wr(3'd3, 32'h0000_7777); rd(3'd3, v); chk("R1 rdata read-only", v, 32'h0);
    wr(3'd4, 32'h1); rd(3'd4, v); chk("R1 status read-only", v, 32'h0);

    // R5 register-number write frame
    wr(3'd2, 32'h0000_A5C3);
    wr(3'd0, cmd_word(2'd1, 2'd1, 5'd5, 5'd3));
    rd(3'd0, v); chk("R8 start set", 32'(v[14]), 32'h1);
    wait_done();
    rd(3'd0, v); chk("R2 cmd fields", v, 32'h0000_10A3 | 32'h0000_0400);

    // R6 R7 register-number read, good turnaround
    phy_data = 16'h1234; phy_ta_ok = 1;
    wr(3'd0, cmd_word(2'd1, 2'd2, 5'h1F, 5'h1F));
    wait_done();
    rd(3'd3, v); chk("R6 read data", v, 32'h1234);
    rd(3'd4, v); chk("R7 status ok", v, 32'h0);

    // R7 failed turnaround
    phy_data = 16'hC0DE; phy_ta_ok = 0;
    wr(3'd0, cmd_word(2'd1, 2'd2, 5'd2, 5'd4));
    wait_done();
    rd(3'd4, v); chk("R7 status fail", v, 32'h1);

    // R7 write frame leaves status
    wr(3'd0, cmd_word(2'd1, 2'd1, 5'd6, 5'd8));
    wait_done();
    rd(3'd4, v); chk("R7 status kept by write", v, 32'h1);

    // R5 extended address frame, R9 command during busy
    wr(3'd1, 32'h0000_BEEF);
    wr(3'd0, cmd_word(2'd0, 2'd0, 5'd2, 5'd7));
    repeat (20) @(negedge clk);
    wr(3'd0, cmd_word(2'd1, 2'd2, 5'd9, 5'd9));
    wait_done();
    rd(3'd0, v); chk("R9 fields unchanged", v, 32'h0000_0047);
    repeat (8 * HALF) @(negedge clk);
    rd(3'd0, v); chk("R9 no extra frame", 32'(v[14]), 32'h0);

    // R6 R7 extended read
    phy_data = 16'h8001; phy_ta_ok = 1;
    wr(3'd0, cmd_word(2'd0, 2'd3, 5'd2, 5'd7));
    wait_done();
    rd(3'd3, v); chk("R6 ext read data", v, 32'h8001);
    rd(3'd4, v); chk("R7 status cleared", v, 32'h0);

    // R6 extended read with post-increment
    phy_data = 16'h7E5A; phy_ta_ok = 1;
    wr(3'd0, cmd_word(2'd0, 2'd2, 5'd3, 5'd1));
    wait_done();
    rd(3'd3, v); chk("R6 ext read-inc data", v, 32'h7E5A);

    // R5 extended write
    wr(3'd2, 32'h0000_0F0F);
    wr(3'd0, cmd_word(2'd0, 2'd1, 5'd3, 5'd1));
    wait_done();
    rd(3'd3, v); chk("R6 rdata kept by write", v, 32'h7E5A);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule